// File: doc/BRIEF.md
# Tamper-Protected Backup Register File

This block is a small bank of 32-bit retention words. Software reaches it through a plain word-wide register bus that carries an address, a write strobe, write data, a read strobe and read data. The words keep their values through an ordinary system reset. Only the separate backup-domain reset clears them.

A tamper controller next to the block drives one flag per tamper source. Each source has a potential-mode bit and a mask bit. The controller also drives a software block level and a one-cycle software erase command.

- Any pending, unmasked flag closes the bus. Reads then return zero and writes are dropped.
- A pending, unmasked flag whose source is in confirmed mode (potential bit 0) holds every word at zero for as long as the flag stays up.
- A masked source has no effect on either access or contents.

Read data is registered. It appears in the cycle after the read strobe and is zero in every cycle that follows no successful read.

Top module: `tamper_backup_regs`

## Requirements
- R1: The bank holds 9 words of 32 bits at byte addresses 0x100 + 4*x, for x = 0 to 8. When access is open, a write stores `bus_wdata` at that edge. A read presents the stored word on `bus_rdata` one cycle later. After a cycle with no successful read, `bus_rdata` is 0.
- R2: Asserting `rst` (system reset) clears `bus_rdata` to 0 and leaves every stored word unchanged.
- R3: Asserting `bkd_rst` (backup-domain reset) sets every word and `bus_rdata` to 0.
- R4: A cycle with `sw_erase` = 1 sets every word to 0 at that edge.
- R5: While any source has flag 1, mask 0 and potential 0 (confirmed mode), every word is held at 0 in each cycle. Words written afterwards start from 0.
- R6: A pending unmasked flag with potential 1 erases nothing. It blocks reads and writes until the flag clears, and the earlier contents are then readable again.
- R7: While `sw_block` = 1, reads return 0 and writes leave the contents unchanged.
- R8: A source with mask 1 neither erases nor blocks, whatever its flag and mode bits.
- R9: An access outside the window, or one with address bits [1:0] not zero, reads as 0 and has no write effect.
- R10: A write and an erase in the same cycle leave the addressed word at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high; clears read data only |
| bkd_rst | input | 1 | Backup-domain reset, synchronous, active high; clears all words |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tmp_flag | input | 9 | Pending tamper flag per source |
| tmp_potential | input | 9 | Per source: 1 = potential mode, 0 = confirmed mode |
| tmp_mask | input | 9 | Per source: 1 = source masked |
| sw_block | input | 1 | Software access block level |
| sw_erase | input | 1 | Software erase command, one cycle |

## Verification
The bench builds the block with its default parameters: 9 words of 32 bits, a 12-bit address, a base of 0x100 and 9 tamper sources. The 12-bit address lets random stimulus reach addresses below the window, above it and misaligned, as well as every in-window word. Nine sources allow confirmed, potential and masked flags on different sources within one run. The directed part also lines up the collisions that matter: erase against write, system reset against stored contents, and a flag arriving while a write is presented.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    // What the storage array does at the next edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_WRITE = 2'd2
    } store_op_e;

    // Access and erase conditions derived from the tamper inputs
    typedef struct packed {
        logic blocked;
        logic erase;
    } guard_t;

    // True when a byte address names a word inside the window
    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] words);
        logic [31:0] limit;
        limit = base + (words << 2);
        return (addr[1:0] == 2'b00) && (addr >= base) && (addr < limit);
    endfunction

endpackage

// File: rtl/bkp_guard.sv
module bkp_guard
    import bkp_pkg::*;
#(
    parameter int NUM_SRC = 9
) (
    input  logic [NUM_SRC-1:0] flag,
    input  logic [NUM_SRC-1:0] potential,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               sw_block,
    input  logic               sw_erase,
    output guard_t             guard
);
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] confirmed;

    always_comb begin
        live          = flag & ~mask;
        confirmed     = live & ~potential;
        guard.blocked = sw_block | (|live);
        guard.erase   = sw_erase | (|confirmed);
    end
endmodule

// File: rtl/bkp_decode.sv
module bkp_decode
    import bkp_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_WORDS = 9,
    parameter logic [31:0] BASE      = 32'h100,
    parameter int          IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [31:0] addr32;

    always_comb begin
        addr32 = 32'(addr);
        hit    = in_window(addr32, BASE, 32'(NUM_WORDS));
        idx    = IDX_W'((addr32 - BASE) >> 2);
    end
endmodule

// File: rtl/bkp_store.sv
module bkp_store
    import bkp_pkg::*;
#(
    parameter int NUM_WORDS = 9,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        dom_rst,
    input  store_op_e                   op,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [DATA_W-1:0]           rd_word,
    output logic [NUM_WORDS*DATA_W-1:0] words_flat
);
    logic [DATA_W-1:0] word_q [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (dom_rst) begin
                word_q[g] <= '0;
            end else if (op == OP_CLEAR) begin
                word_q[g] <= '0;
            end else if (op == OP_WRITE && wr_idx == IDX_W'(g)) begin
                word_q[g] <= wr_data;
            end
        end
        assign words_flat[g*DATA_W +: DATA_W] = word_q[g];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_word = word_q[i];
        end
    end
endmodule

// File: rtl/tamper_backup_regs.sv
module tamper_backup_regs
    import bkp_pkg::*;
#(
    parameter int          NUM_WORDS = 9,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int          NUM_SRC   = 9,
    parameter logic [31:0] BASE      = 32'h100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bkd_rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] tmp_flag,
    input  logic [NUM_SRC-1:0] tmp_potential,
    input  logic [NUM_SRC-1:0] tmp_mask,
    input  logic               sw_block,
    input  logic               sw_erase
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    guard_t                      guard;
    logic                        addr_hit;
    logic [IDX_W-1:0]            addr_idx;
    store_op_e                   op;
    logic [DATA_W-1:0]           rd_word;
    logic [NUM_WORDS*DATA_W-1:0] words_flat;

    bkp_guard #(.NUM_SRC(NUM_SRC)) u_guard (
        .flag      (tmp_flag),
        .potential (tmp_potential),
        .mask      (tmp_mask),
        .sw_block  (sw_block),
        .sw_erase  (sw_erase),
        .guard     (guard)
    );

    bkp_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .BASE      (BASE),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr (bus_addr),
        .hit  (addr_hit),
        .idx  (addr_idx)
    );

    // Erase outranks any write presented in the same cycle
    always_comb begin
        if (guard.erase)                              op = OP_CLEAR;
        else if (bus_wr && addr_hit && !guard.blocked) op = OP_WRITE;
        else                                          op = OP_HOLD;
    end

    bkp_store #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk        (clk),
        .dom_rst    (bkd_rst),
        .op         (op),
        .wr_idx     (addr_idx),
        .wr_data    (bus_wdata),
        .rd_idx     (addr_idx),
        .rd_word    (rd_word),
        .words_flat (words_flat)
    );

    always_ff @(posedge clk) begin
        if (rst || bkd_rst) begin
            bus_rdata <= '0;
        end else if (bus_rd && addr_hit && !guard.blocked) begin
            bus_rdata <= rd_word;
        end else begin
            bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/tamper_backup_regs_chk.sv
module tamper_backup_regs_chk #(
    parameter int NUM_WORDS = 9,
    parameter int DATA_W    = 32,
    parameter int NUM_SRC   = 9
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bkd_rst,
    input logic                        bus_wr,
    input logic [NUM_SRC-1:0]          tmp_flag,
    input logic [NUM_SRC-1:0]          tmp_potential,
    input logic [NUM_SRC-1:0]          tmp_mask,
    input logic                        sw_block,
    input logic                        sw_erase,
    input logic                        addr_hit,
    input logic [NUM_WORDS*DATA_W-1:0] words_flat,
    input logic [DATA_W-1:0]           bus_rdata
);
    logic [NUM_SRC-1:0] live;
    logic               conf_pend;
    logic               closed;

    assign live      = tmp_flag & ~tmp_mask;
    assign conf_pend = |(live & ~tmp_potential);
    assign closed    = sw_block | (|live);

    AST_BKD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bkd_rst |=> words_flat == '0);                                       // R3
    AST_SYS_KEEP: assert property (@(posedge clk) disable iff (bkd_rst)
        rst && !bus_wr && !sw_erase && !conf_pend |=> $stable(words_flat));  // R2
    AST_ERASE_CMD: assert property (@(posedge clk) disable iff (bkd_rst)
        sw_erase |=> words_flat == '0);                                      // R4
    AST_CONF_HOLD: assert property (@(posedge clk) disable iff (bkd_rst)
        conf_pend |=> words_flat == '0);                                     // R5
    AST_CLOSED_RD: assert property (@(posedge clk) disable iff (rst || bkd_rst)
        closed |=> bus_rdata == '0);                                         // R7
    AST_CLOSED_WR: assert property (@(posedge clk) disable iff (bkd_rst)
        closed && !sw_erase && !conf_pend |=> $stable(words_flat));          // R6
    AST_WINDOW_RD: assert property (@(posedge clk) disable iff (rst || bkd_rst)
        !addr_hit |=> bus_rdata == '0);                                      // R9
endmodule

bind tamper_backup_regs tamper_backup_regs_chk #(
    .NUM_WORDS (NUM_WORDS),
    .DATA_W    (DATA_W),
    .NUM_SRC   (NUM_SRC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bkd_rst       (bkd_rst),
    .bus_wr        (bus_wr),
    .tmp_flag      (tmp_flag),
    .tmp_potential (tmp_potential),
    .tmp_mask      (tmp_mask),
    .sw_block      (sw_block),
    .sw_erase      (sw_erase),
    .addr_hit      (addr_hit),
    .words_flat    (words_flat),
    .bus_rdata     (bus_rdata)
);

// File: tb/tamper_backup_regs_bench.sv
module tamper_backup_regs_bench;
    localparam int NW = 9;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NS = 9;

    logic          clk = 1'b0;
    logic          rst, bkd_rst, bus_wr, bus_rd, sw_block, sw_erase;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [NS-1:0] tmp_flag, tmp_potential, tmp_mask;

    int n_checks = 0;
    int n_fails  = 0;
    logic [DW-1:0] mdl [NW];

    always #5 clk = ~clk;

    tamper_backup_regs u_tamper_backup_regs (
        .clk(clk), .rst(rst), .bkd_rst(bkd_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .tmp_flag(tmp_flag),
        .tmp_potential(tmp_potential), .tmp_mask(tmp_mask),
        .sw_block(sw_block), .sw_erase(sw_erase)
    );

    function automatic logic win(input logic [AW-1:0] a);
        return a[1:0] == 2'b00 && a >= 12'h100 && a <= 12'h120;
    endfunction

    function automatic int widx(input logic [AW-1:0] a);
        return (int'(a) - 'h100) / 4;
    endfunction

    function automatic logic is_closed();
        return sw_block || ((tmp_flag & ~tmp_mask) != '0);
    endfunction

    function automatic logic is_erase();
        return sw_erase || ((tmp_flag & ~tmp_mask & ~tmp_potential) != '0);
    endfunction

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic clear_tamper();
        tmp_flag = '0; tmp_potential = '0; tmp_mask = '0;
        sw_block = 0; sw_erase = 0;
    endtask

    // One clock: predict, let the edge pass, compare, advance model
    task automatic step(input string tag);
        logic [DW-1:0] exp_rd;
        logic [DW-1:0] nxt [NW];
        for (int i = 0; i < NW; i++) nxt[i] = mdl[i];
        if (rst || bkd_rst) exp_rd = '0;
        else if (bus_rd && win(bus_addr) && !is_closed()) exp_rd = mdl[widx(bus_addr)];
        else exp_rd = '0;
        if (bkd_rst || is_erase()) begin
            for (int i = 0; i < NW; i++) nxt[i] = '0;
        end else if (bus_wr && win(bus_addr) && !is_closed()) begin
            nxt[widx(bus_addr)] = bus_wdata;
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (bus_rdata !== exp_rd) begin
            n_fails++;
            $display("FAIL %s: rdata actual %h expected %h", tag, bus_rdata, exp_rd);
        end
        for (int i = 0; i < NW; i++) mdl[i] = nxt[i];
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        step(tag);
        idle();
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        step(tag);
        idle();
        step(tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NW; i++) rd(12'h100 + 12'(4 * i), tag);
    endtask

    task automatic fill(input logic [DW-1:0] seed, input string tag);
        for (int i = 0; i < NW; i++) wr(12'h100 + 12'(4 * i), seed ^ DW'(i * 32'h01010101), tag);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) mdl[i] = 'x;
        rst = 1; bkd_rst = 1; idle(); clear_tamper();
        @(negedge clk);
        // R3: backup-domain reset clears everything
        repeat (3) step("R3");
        rst = 0; bkd_rst = 0;
        read_all("R3");

        // R1: write and read back every word
        fill(32'hA5C30F00, "R1");
        read_all("R1");

        // R2: system reset keeps contents
        rst = 1; bus_addr = 12'h104; bus_rd = 1;
        repeat (2) step("R2");
        rst = 0; idle();
        read_all("R2");

        // R7: software block
        sw_block = 1;
        wr(12'h100, 32'hDEADBEEF, "R7");
        rd(12'h100, "R7");
        sw_block = 0;
        read_all("R7");

        // R6: potential-mode flag blocks but keeps contents
        tmp_flag[2] = 1; tmp_potential[2] = 1;
        wr(12'h108, 32'h11112222, "R6");
        rd(12'h108, "R6");
        clear_tamper();
        read_all("R6");

        // R8: masked confirmed source does nothing
        tmp_flag[4] = 1; tmp_mask[4] = 1;
        wr(12'h10C, 32'h0BADF00D, "R8");
        rd(12'h10C, "R8");
        clear_tamper();
        read_all("R8");

        // R9: outside window and misaligned
        wr(12'h0FC, 32'h12345678, "R9");
        wr(12'h124, 32'h12345678, "R9");
        wr(12'h102, 32'h12345678, "R9");
        rd(12'h0FC, "R9");
        rd(12'h124, "R9");
        rd(12'h103, "R9");
        read_all("R9");

        // R5: confirmed flag holds contents at zero
        tmp_flag[6] = 1;
        wr(12'h110, 32'hCAFE0001, "R5");
        repeat (3) step("R5");
        clear_tamper();
        read_all("R5");
        wr(12'h110, 32'h00000077, "R5");
        rd(12'h110, "R5");

        // R10: erase and write together
        fill(32'h5A5A0000, "R10");
        sw_erase = 1;
        wr(12'h114, 32'hFFFF0000, "R10");
        sw_erase = 0;
        read_all("R10");

        // R4: software erase alone
        fill(32'h3C3C3C3C, "R4");
        sw_erase = 1; step("R4"); sw_erase = 0;
        read_all("R4");

        // R3: backup-domain reset mid-run
        fill(32'h77665544, "R3");
        bkd_rst = 1; step("R3"); bkd_rst = 0;
        read_all("R3");

        // R1: random traffic with occasional tamper activity
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom % 10);
            bus_addr = (r < 8) ? 12'h100 + 12'(4 * ($urandom % NW)) : 12'($urandom);
            bus_wr    = ($urandom % 2) == 0;
            bus_rd    = ($urandom % 3) != 0;
            bus_wdata = $urandom;
            sw_block  = ($urandom % 8) == 0;
            sw_erase  = ($urandom % 40) == 0;
            rst       = ($urandom % 50) == 0;
            tmp_flag      = ($urandom % 12 == 0) ? NS'(1 << ($urandom % NS)) : '0;
            tmp_potential = NS'($urandom);
            tmp_mask      = NS'($urandom);
            step("R1");
        end
        rst = 0; idle(); clear_tamper();
        read_all("R1");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule